// File: doc/BRIEF.md
# Frame Skew Meter

This block measures how far an external frame-evaluation signal lags the device frame pulse. It samples the serial master clock, the frame pulse and the evaluation pin on a faster system clock. It counts whole master clock periods from the reference frame-pulse edge to the first evaluation edge. It also records in which half of the master clock period that edge fell. Software uses the result to program per-stream input offsets and data-latch edges, and the measured shift runs from 0 to 4.5 master clocks in half-clock steps.

A control bit starts and stops a measurement. The control bit has to have been low across at least one frame boundary. On its rising edge the block waits for the next reference edge, measures over one frame, and sets the done flag at the reference edge after that. The result stays in a 16-bit status word until the control bit drops, and the drop clears the word. A mode input selects the reference edges. In mode 0 the frame pulse is active low and falling edges count. In mode 1 the pulse is active high and rising edges count.

Top module: `frame_skew_meter`

## Requirements
- R1: After reset the status word is 0x0000, and bits 15-13 read zero at all times.
- R2: A rising edge of `start_bit` after an armed low period makes the done flag (status bit 12) rise at the second reference edge after the start, not at the first.
- R3: The block is armed only when a reference edge is seen while `start_bit` is low. A rising edge of `start_bit` with no such edge since the last start produces no measurement, and the status stays zero.
- R4: With `bus_mode` = 0, only falling edges of the frame pulse and of the evaluation input are used, and rising edges of either are ignored.
- R5: With `bus_mode` = 1, only rising edges of the frame pulse and of the evaluation input are used.
- R6: Status bit 11 is 1 when the sampled master clock was high at the evaluation edge and 0 when it was low.
- R7: Status bits 10-0 hold the number of master clock rising edges after the reference edge, up to and including the sample of the evaluation edge.
- R8: Only the first evaluation edge inside the measurement frame is recorded. Edges that arrive before the measurement frame starts, and later edges in the same frame, are ignored.
- R9: If no evaluation edge arrives during the measurement frame, the result is a count of 2047 with bit 11 = 0 (status 0x17FF). The count also saturates at 2047 in a long frame.
- R10: One cycle after `start_bit` goes low, the status word is zero.
- R11: While `start_bit` stays high after completion, the status word does not change, whatever happens on the inputs in later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_mode | input | 1 | 0: falling reference edges, 1: rising reference edges |
| start_bit | input | 1 | Measurement control bit from the control register |
| mclk_i | input | 1 | Serial master clock, sampled |
| fpulse_i | input | 1 | Device frame pulse |
| feval_i | input | 1 | Frame evaluation input |
| status_o | output | 16 | {3'b0, done, phase, count[10:0]} |

## Verification
The hardest case to reach is the saturated result. The measurement frame must outlast 2047 master clock periods with no evaluation edge, so the bench stretches one frame to 2100 master clocks while holding the evaluation pin idle. The other hard cases are edge orderings inside a single frame. The stimulus places a wrong-polarity edge and a second edge around the real one, and an edge before the measurement frame, so it can show that only the first valid edge is kept.

// File: rtl/frame_skew_pkg.sv
package frame_skew_pkg;
   typedef enum logic [2:0] {
      MS_IDLE,
      MS_WAIT,
      MS_MEAS,
      MS_DONE,
      MS_HOLD
   } meas_state_t;

   localparam int SIG_MCLK = 0;
   localparam int SIG_FP   = 1;
   localparam int SIG_FE   = 2;
   localparam int SIG_N    = 3;
endpackage

// File: rtl/frame_skew_sync.sv
module frame_skew_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (STAGES < 0) begin : g_bad
         $error("frame_skew_sync: STAGES must not be negative");
      end
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [WIDTH-1:0] pipe [STAGES];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
            end else begin
               pipe[0] <= d_i;
               for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            end
         end
         assign q_o = pipe[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/frame_skew_edge.sv
module frame_skew_edge #(
   parameter int WIDTH = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl_i,
   output logic [WIDTH-1:0] rise_o,
   output logic [WIDTH-1:0] fall_o
);
   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~prev_q;
   assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/frame_skew_core.sv
module frame_skew_core
   import frame_skew_pkg::*;
#(
   parameter int CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             ref_evt_i,
   input  logic             fe_evt_i,
   input  logic             mrise_i,
   input  logic             mlevel_i,
   output logic             done_o,
   output logic             phase_o,
   output logic [CNT_W-1:0] count_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   meas_state_t      state_q;
   logic             start_q;
   logic             armed_q;
   logic             got_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;
   logic [CNT_W-1:0] cap_cnt_q;
   logic             cap_ph_q;
   logic             done_q;

   always_comb begin
      cnt_nxt = cnt_q;
      if (mrise_i && (cnt_q != CNT_MAX)) cnt_nxt = cnt_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= MS_IDLE;
         start_q   <= 1'b0;
         armed_q   <= 1'b0;
         got_q     <= 1'b0;
         cnt_q     <= '0;
         cap_cnt_q <= '0;
         cap_ph_q  <= 1'b0;
         done_q    <= 1'b0;
      end else begin
         start_q <= start_i;
         if (!start_i) begin
            state_q   <= MS_IDLE;
            done_q    <= 1'b0;
            got_q     <= 1'b0;
            cap_cnt_q <= '0;
            cap_ph_q  <= 1'b0;
            if (ref_evt_i) armed_q <= 1'b1;
         end else begin
            unique case (state_q)
               MS_IDLE: begin
                  if (!start_q && armed_q) state_q <= MS_WAIT;
                  else                     state_q <= MS_HOLD;
                  armed_q <= 1'b0;
               end
               MS_WAIT: begin
                  if (ref_evt_i) begin
                     cnt_q   <= '0;
                     got_q   <= 1'b0;
                     state_q <= MS_MEAS;
                  end
               end
               MS_MEAS: begin
                  if (ref_evt_i) begin
                     done_q  <= 1'b1;
                     state_q <= MS_DONE;
                     if (!got_q) begin
                        cap_cnt_q <= CNT_MAX;
                        cap_ph_q  <= 1'b0;
                     end
                  end else begin
                     cnt_q <= cnt_nxt;
                     if (fe_evt_i && !got_q) begin
                        cap_cnt_q <= cnt_nxt;
                        cap_ph_q  <= mlevel_i;
                        got_q     <= 1'b1;
                     end
                  end
               end
               default: state_q <= state_q;
            endcase
         end
      end
   end

   assign done_o  = done_q;
   assign phase_o = cap_ph_q;
   assign count_o = cap_cnt_q;
endmodule

// File: rtl/frame_skew_meter.sv
module frame_skew_meter
   import frame_skew_pkg::*;
#(
   parameter int CNT_W       = 11,
   parameter int SYNC_STAGES = 2,
   parameter int STAT_W      = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_mode,
   input  logic              start_bit,
   input  logic              mclk_i,
   input  logic              fpulse_i,
   input  logic              feval_i,
   output logic [STAT_W-1:0] status_o
);
   localparam int PHASE_BIT = CNT_W;
   localparam int DONE_BIT  = CNT_W + 1;

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("frame_skew_meter: CNT_W too small");
      end
      if (STAT_W < DONE_BIT + 1) begin : g_bad_stat
         $error("frame_skew_meter: STAT_W cannot hold the result");
      end
   endgenerate

   logic [SIG_N-1:0] raw_lvl;
   logic [SIG_N-1:0] syn_lvl;
   logic [SIG_N-1:0] rise;
   logic [SIG_N-1:0] fall;
   logic             ref_evt;
   logic             fe_evt;
   logic             done;
   logic             phase;
   logic [CNT_W-1:0] count;

   always_comb begin
      raw_lvl           = '0;
      raw_lvl[SIG_MCLK] = mclk_i;
      raw_lvl[SIG_FP]   = fpulse_i;
      raw_lvl[SIG_FE]   = feval_i;
   end

   frame_skew_sync #(.WIDTH(SIG_N), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_lvl),
      .q_o   (syn_lvl)
   );

   frame_skew_edge #(.WIDTH(SIG_N)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (syn_lvl),
      .rise_o (rise),
      .fall_o (fall)
   );

   assign ref_evt = bus_mode ? rise[SIG_FP] : fall[SIG_FP];
   assign fe_evt  = bus_mode ? rise[SIG_FE] : fall[SIG_FE];

   frame_skew_core #(.CNT_W(CNT_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_bit),
      .ref_evt_i (ref_evt),
      .fe_evt_i  (fe_evt),
      .mrise_i   (rise[SIG_MCLK]),
      .mlevel_i  (syn_lvl[SIG_MCLK]),
      .done_o    (done),
      .phase_o   (phase),
      .count_o   (count)
   );

   always_comb begin
      status_o = '0;
      if (done) begin
         status_o[CNT_W-1:0] = count;
         status_o[PHASE_BIT] = phase;
         status_o[DONE_BIT]  = 1'b1;
      end
   end
endmodule

// File: rtl/frame_skew_chk.sv
module frame_skew_chk #(
   parameter int CNT_W  = 11,
   parameter int STAT_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_bit,
   input logic [STAT_W-1:0] status_o
);
   logic done;
   assign done = status_o[CNT_W+1];

   assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !start_bit |=> (status_o == '0));

   assert_fall_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(done) |-> $past(!start_bit));

   assert_rise_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> ($past(start_bit) && start_bit));

   assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(done) && $past(start_bit)) |-> $stable(status_o));
endmodule

bind frame_skew_meter frame_skew_chk #(.CNT_W(CNT_W), .STAT_W(STAT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_bit (start_bit),
   .status_o  (status_o)
);

// File: tb/frame_skew_meter_bench.sv
module frame_skew_meter_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_mode = 1'b0;
   logic        start_bit = 1'b0;
   logic        mclk_i = 1'b0;
   logic        fpulse_i = 1'b1;
   logic        feval_i = 1'b1;
   logic [15:0] status_o;

   int errors = 0;
   int checks = 0;
   int tick   = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   frame_skew_meter u_frame_skew_meter (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_mode  (bus_mode),
      .start_bit (start_bit),
      .mclk_i    (mclk_i),
      .fpulse_i  (fpulse_i),
      .feval_i   (feval_i),
      .status_o  (status_o)
   );

   // mode, offset in system ticks after the reference edge
   localparam int NVEC = 6;
   localparam int VEC [NVEC][2] = '{'{0, 2}, '{0, 3}, '{0, 13}, '{1, 8}, '{1, 30}, '{1, 70}};

   task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: status=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tk();
      @(negedge clk);
      tick = tick + 1;
      mclk_i = ((tick % 8) < 4);
   endtask

   task automatic steps(input int n);
      for (int i = 0; i < n; i++) tk();
   endtask

   function automatic logic act_lvl(input logic mode);
      return mode;
   endfunction

   function automatic logic [15:0] expect_val(input int d);
      int c;
      logic ph;
      c  = (1 + d) / 8;
      ph = (((1 + d) % 8) < 4);
      if (c > 2047) c = 2047;
      return {3'b000, 1'b1, ph, c[10:0]};
   endfunction

   // one frame: reference edge at rel 0, optional level changes on feval_i
   task automatic frame(input int len, input int d1, input logic v1,
                        input int d2, input logic v2);
      while ((tick % 8) != 0) tk();
      tk();
      fpulse_i = act_lvl(bus_mode);
      for (int rel = 1; rel < len * 8 - 1; rel++) begin
         tk();
         if (rel == 4) fpulse_i = ~act_lvl(bus_mode);
         if (rel == d1) feval_i = v1;
         if (rel == d2) feval_i = v2;
      end
   endtask

   task automatic idle_inputs(input logic mode);
      bus_mode = mode;
      fpulse_i = ~act_lvl(mode);
      feval_i  = ~act_lvl(mode);
   endtask

   // arming frame, start, measurement frame, closing reference edge
   task automatic measure(input logic mode, input int len, input int d1, input logic v1,
                          input int d2, input logic v2, input string req);
      start_bit = 1'b0;
      idle_inputs(mode);
      steps(12);
      frame(4, -1, 1'b0, -1, 1'b0);
      start_bit = 1'b1;
      steps(4);
      frame(len, d1, v1, d2, v2);
      check(status_o, 16'h0000, {req, " R2 not done after first reference edge"});
      frame(4, -1, 1'b0, -1, 1'b0);
   endtask

   initial begin
      steps(5);
      rst_n = 1'b1;
      steps(2);
      check(status_o, 16'h0000, "R1 reset value");

      // table walk: R4 R5 R6 R7 by mode and offset
      for (int v = 0; v < NVEC; v++) begin
         logic m;
         int   d;
         m = VEC[v][0][0];
         d = VEC[v][1];
         measure(m, 12, d, act_lvl(m), d + 3, ~act_lvl(m), "R4/R5");
         check(status_o, expect_val(d), m ? "R5 R6 R7 rising mode" : "R4 R6 R7 falling mode");
         check({status_o[15:13], 13'd0}, 16'h0000, "R1 upper bits zero");
         start_bit = 1'b0;
         tk();
         tk();
         check(status_o, 16'h0000, "R10 clear on start low");
      end

      // R11: result held while start stays high
      measure(1'b0, 12, 10, 1'b0, 13, 1'b1, "R11");
      check(status_o, expect_val(10), "R11 first result");
      frame(12, 40, 1'b0, 43, 1'b1);
      frame(12, 20, 1'b0, 23, 1'b1);
      check(status_o, expect_val(10), "R11 result unchanged in later frames");

      // R3: start raised again with no reference edge while low
      start_bit = 1'b0;
      tk();
      tk();
      start_bit = 1'b1;
      frame(12, 9, 1'b0, 12, 1'b1);
      frame(12, 9, 1'b0, 12, 1'b1);
      frame(4, -1, 1'b0, -1, 1'b0);
      check(status_o, 16'h0000, "R3 unarmed start ignored");

      // R8: edge before measurement frame and a second edge in frame
      start_bit = 1'b0;
      idle_inputs(1'b1);
      steps(12);
      frame(4, -1, 1'b0, -1, 1'b0);
      start_bit = 1'b1;
      steps(3);
      feval_i = 1'b1;
      steps(3);
      feval_i = 1'b0;
      steps(3);
      frame(12, 20, 1'b1, 45, 1'b0);
      check(status_o, 16'h0000, "R8 not done yet");
      frame(12, 60, 1'b1, -1, 1'b0);
      steps(8);
      check(status_o, expect_val(20), "R8 first in-frame edge kept");

      // R4: wrong-polarity edge first in falling mode
      start_bit = 1'b0;
      idle_inputs(1'b0);
      steps(12);
      frame(4, -1, 1'b0, -1, 1'b0);
      start_bit = 1'b1;
      steps(3);
      feval_i = 1'b0;
      steps(3);
      frame(12, 17, 1'b1, 50, 1'b0);
      frame(4, -1, 1'b0, -1, 1'b0);
      steps(8);
      check(status_o, expect_val(50), "R4 rising edge ignored in falling mode");

      // R9: no evaluation edge in a frame longer than the count range
      measure(1'b0, 2100, -1, 1'b0, -1, 1'b0, "R9");
      steps(8);
      check(status_o, 16'h17FF, "R9 saturated result");
      start_bit = 1'b0;
      tk();
      tk();
      check(status_o, 16'h0000, "R10 clear after saturation");

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule